// File: doc/BRIEF.md
# Data Link Receive Byte Buffer

This block gathers the serial bits recovered from a framed line's data link channel (or from the signalling frame-bit position) into bytes. Each cycle in which a strobe marks a valid bit, the bit enters an 8-bit assembly register, least significant bit first. After every eighth valid bit, the assembled byte is copied into a holding register for the host, and a buffer-full flag is raised.

Each completed byte is compared with two programmable match bytes. A match flag lets the host skip routine link traffic and respond only to a pattern it is waiting for. Each flag has its own enable input, and the two enabled flags drive one shared active-low interrupt. A read strobe from the host returns the held byte and clears the flags. If a byte completes while the previous one is still unread, the new byte replaces it and an overrun flag is raised. Bit recovery and host address decoding take place outside the block.

Top module: `dlink_rx_bytebuf`

## Requirements
- R1: While rst_n is sampled low, and after it is released, full_flag, match_flag and overrun_flag are 0, irq_n is 1 and rd_data is 8'h00.
- R2: Bits are assembled least significant bit first: the first valid bit of a byte ends up in rd_data bit 0 and the eighth ends up in bit 7. A cycle with bit_valid low does not change the assembly.
- R3: The held byte appears on rd_data, and full_flag is 1, from the second rising edge after the edge that samples the eighth valid bit.
- R4: Byte boundaries fall after every eighth valid bit, counting from the release of reset. They do not depend on gaps between valid bits.
- R5: When a byte completes, match_flag takes the value 1 if the byte equals match_a or match_b, and 0 otherwise. It therefore describes the byte currently held.
- R6: A cycle with rd_stb high and no byte completing clears full_flag, match_flag and overrun_flag at that clock edge. rd_data keeps the held byte.
- R7: A byte that completes before the host has read the previous one replaces the held byte on rd_data.
- R8: overrun_flag is set when a byte completes while full_flag is 1 and rd_stb is low. It stays set until a read.
- R9: irq_n is 0 exactly when (full_flag and full_ie) or (match_flag and match_ie) is true.
- R10: When rd_stb coincides with the latching of a new byte, the new byte is held, full_flag is 1 and overrun_flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | Strobe marking a valid data link bit this cycle |
| bit_in | input | 1 | Data link bit value |
| match_a | input | 8 | First programmable match byte |
| match_b | input | 8 | Second programmable match byte |
| full_ie | input | 1 | Enables buffer-full onto irq_n |
| match_ie | input | 1 | Enables match onto irq_n |
| rd_stb | input | 1 | Host read strobe; clears status flags |
| rd_data | output | 8 | Held byte |
| full_flag | output | 1 | A byte is waiting to be read |
| match_flag | output | 1 | Held byte equals a match byte |
| overrun_flag | output | 1 | An unread byte was overwritten |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sends bytes with gaps between bits, so a design that counted cycles instead of valid bits would cut bytes at the wrong place. It sends asymmetric byte values, so a design that shifted most significant bit first would show a reversed byte. It follows a matching byte with a non-matching one, which exposes a match flag that sticks, or one that compares against only one match byte. It also places a read on the same cycle that a new byte lands. A design that let the read win there would lose the new byte's full flag or report a false overrun.

// File: rtl/dlrx_pkg.sv
// Shared constants for the data link receive byte buffer.
// Assumes one byte width and a fixed count of match comparators.
package dlrx_pkg;
    localparam int BYTE_W    = 8;
    localparam int NUM_MATCH = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/dlrx_shifter.sv
// Serial-to-byte assembler: shifts valid bits in LSB first and emits a
// one-cycle done pulse with the assembled word after every W valid bits.
// Assumes the bit counter starts from zero at reset release.
module dlrx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_valid,
    input  logic         bit_in,
    output logic         done,
    output logic [W-1:0] word
);
    localparam int CNT_W = (W > 1) ? $clog2(W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic [W-1:0]     sr_q;
    logic [CNT_W-1:0] cnt_q;

    // Shift register: new bit enters at the top, so the first bit ends at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sr_q <= '0;
        else if (bit_valid)
            sr_q <= {bit_in, sr_q[W-1:1]};
    end

    // Bit counter: counts valid bits modulo W.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (bit_valid)
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end

    // Output stage: register the completed word and a done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            word <= '0;
        end else begin
            done <= bit_valid && (cnt_q == LAST);
            if (bit_valid && (cnt_q == LAST))
                word <= {bit_in, sr_q[W-1:1]};
        end
    end

    // A completed word is only reported after a valid bit (R4).
    assert_done_after_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(bit_valid));
    // Consecutive done pulses are impossible for W > 1 (R4).
    assert_done_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/dlrx_matcher.sv
// Compares a byte against N programmable patterns; reports any equality.
// Assumes the patterns are held stable by the host while bytes arrive.
module dlrx_matcher #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic [W-1:0]        word,
    input  logic [N-1:0][W-1:0] patterns,
    output logic                hit
);
    logic [N-1:0] eq;

    // One comparator per pattern.
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign eq[i] = (word == patterns[i]);
    end

    // Reduce the comparator results.
    always_comb hit = |eq;
endmodule

// File: rtl/dlrx_status.sv
// Holding register, status flags and interrupt combination.
// Assumes done pulses are single-cycle; a completing byte takes priority
// over a read arriving in the same cycle.
module dlrx_status #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         done,
    input  logic [W-1:0] word,
    input  logic         hit,
    input  logic         rd_stb,
    input  logic         full_ie,
    input  logic         match_ie,
    output logic [W-1:0] hold,
    output logic         full_q,
    output logic         match_q,
    output logic         ovr_q,
    output logic         irq_n
);
    // Holding register: captures each completed byte, overwriting any unread one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold <= '0;
        else if (done)
            hold <= word;
    end

    // Status flags: set by completion, cleared by a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q  <= 1'b0;
            match_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (done) begin
            full_q  <= 1'b1;
            match_q <= hit;
            ovr_q   <= ovr_q | (full_q & ~rd_stb);
        end else if (rd_stb) begin
            full_q  <= 1'b0;
            match_q <= 1'b0;
            ovr_q   <= 1'b0;
        end
    end

    // Interrupt: active low whenever an enabled flag is set.
    always_comb irq_n = ~((full_q & full_ie) | (match_q & match_ie));

    assert_full_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> full_q);
    assert_match_tracks_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (match_q == $past(hit)));
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !done) |=> (!full_q && !match_q && !ovr_q));
    assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_q) |-> ($past(full_q) && $past(done) && !$past(rd_stb)));
    assert_no_overrun_on_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rd_stb) |=> !ovr_q);
endmodule

// File: rtl/dlink_rx_bytebuf.sv
// Data link receive byte buffer top: assembles bits into bytes, compares
// each byte with two match bytes, and raises maskable status and interrupt.
// Assumes bit recovery and host bus decoding are done outside.
module dlink_rx_bytebuf
    import dlrx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_valid,
    input  logic        bit_in,
    input  logic [7:0]  match_a,
    input  logic [7:0]  match_b,
    input  logic        full_ie,
    input  logic        match_ie,
    input  logic        rd_stb,
    output logic [7:0]  rd_data,
    output logic        full_flag,
    output logic        match_flag,
    output logic        overrun_flag,
    output logic        irq_n
);
    logic                            done;
    byte_t                           word;
    logic                            hit;
    logic [NUM_MATCH-1:0][BYTE_W-1:0] pats;

    // Gather the match bytes into the comparator array.
    always_comb pats = {match_b, match_a};

    dlrx_shifter #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .done(done), .word(word)
    );

    dlrx_matcher #(.W(BYTE_W), .N(NUM_MATCH)) u_match (
        .word(word), .patterns(pats), .hit(hit)
    );

    dlrx_status #(.W(BYTE_W)) u_stat (
        .clk(clk), .rst_n(rst_n), .done(done), .word(word), .hit(hit),
        .rd_stb(rd_stb), .full_ie(full_ie), .match_ie(match_ie),
        .hold(rd_data), .full_q(full_flag), .match_q(match_flag),
        .ovr_q(overrun_flag), .irq_n(irq_n)
    );

    // Interrupt only with an enabled, set flag (R9).
    assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((full_flag && full_ie) || (match_flag && match_ie)));
endmodule

// File: tb/dlink_rx_bytebuf_test.sv
module dlink_rx_bytebuf_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_valid = 1'b0, bit_in = 1'b0;
    logic [7:0] match_a = 8'h7E, match_b = 8'hC3;
    logic full_ie = 1'b0, match_ie = 1'b0, rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic full_flag, match_flag, overrun_flag, irq_n;
    int checks = 0, failures = 0;
    logic done_flag = 1'b0;

    always #10 clk = ~clk;

    dlink_rx_bytebuf uut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .match_a(match_a), .match_b(match_b), .full_ie(full_ie),
        .match_ie(match_ie), .rd_stb(rd_stb), .rd_data(rd_data),
        .full_flag(full_flag), .match_flag(match_flag),
        .overrun_flag(overrun_flag), .irq_n(irq_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Send one bit, followed by gap idle cycles.
    task automatic send_bit(input logic b, input int gap);
        @(negedge clk); bit_valid = 1'b1; bit_in = b;
        @(negedge clk); bit_valid = 1'b0;
        for (int g = 0; g < gap; g++) @(negedge clk);
    endtask

    // Send a byte LSB first; then wait until the flags have updated.
    task automatic send_byte(input logic [7:0] v, input int gap);
        for (int i = 0; i < 8; i++) send_bit(v[i], gap);
        @(negedge clk);
    endtask

    // Host read: pulse rd_stb for one cycle, returning the data seen.
    task automatic host_read(output logic [7:0] d);
        @(negedge clk); rd_stb = 1'b1; d = rd_data;
        @(negedge clk); rd_stb = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 full", full_flag, 0);
        chk("R1 match", match_flag, 0);
        chk("R1 overrun", overrun_flag, 0);
        chk("R1 irq_n", irq_n, 1);
        chk("R1 data", rd_data, 8'h00);
    endtask

    task automatic t_lsb_first;
        logic [7:0] d;
        send_byte(8'h35, 0);
        chk("R2 data lsb-first", rd_data, 8'h35);
        chk("R3 full", full_flag, 1);
        chk("R5 no match", match_flag, 0);
        host_read(d);
        chk("R6 read data", d, 8'h35);
        chk("R6 full cleared", full_flag, 0);
        chk("R6 data kept", rd_data, 8'h35);
    endtask

    task automatic t_latency;
        // eighth bit sampled at edge E; flags set at E+1
        for (int i = 0; i < 7; i++) send_bit(1'b0, 0);
        @(negedge clk); bit_valid = 1'b1; bit_in = 1'b1;
        @(negedge clk); bit_valid = 1'b0;
        chk("R3 not yet full", full_flag, 0);
        @(negedge clk);
        chk("R3 full at second edge", full_flag, 1);
        chk("R3 data", rd_data, 8'h80);
        begin logic [7:0] d; host_read(d); end
    endtask

    task automatic t_gaps;
        logic [7:0] d;
        send_byte(8'hA6, 3);
        chk("R4 gapped byte", rd_data, 8'hA6);
        chk("R4 full", full_flag, 1);
        host_read(d);
        // five bits then idle: no byte yet
        for (int i = 0; i < 5; i++) send_bit(1'b1, 1);
        repeat (6) @(negedge clk);
        chk("R4 partial no full", full_flag, 0);
        for (int i = 0; i < 3; i++) send_bit(1'b0, 0);
        @(negedge clk);
        chk("R2 partial byte", rd_data, 8'h1F);
        host_read(d);
    endtask

    task automatic t_match;
        logic [7:0] d;
        match_ie = 1'b1;
        send_byte(8'h7E, 0);
        chk("R5 match a", match_flag, 1);
        chk("R9 irq on match", irq_n, 0);
        host_read(d);
        chk("R6 match cleared", match_flag, 0);
        chk("R9 irq released", irq_n, 1);
        send_byte(8'hC3, 1);
        chk("R5 match b", match_flag, 1);
        send_byte(8'h3C, 0);
        chk("R5 new byte no match", match_flag, 0);
        chk("R9 full masked", irq_n, 1);
        chk("R8 overrun", overrun_flag, 1);
        chk("R7 overwritten", rd_data, 8'h3C);
        host_read(d);
        chk("R6 overrun cleared", overrun_flag, 0);
        match_ie = 1'b0;
    endtask

    task automatic t_full_irq;
        logic [7:0] d;
        full_ie = 1'b1;
        send_byte(8'h01, 0);
        chk("R9 irq on full", irq_n, 0);
        chk("R8 no overrun", overrun_flag, 0);
        host_read(d);
        chk("R9 irq cleared", irq_n, 1);
        full_ie = 1'b0;
    endtask

    task automatic t_simul;
        logic [7:0] d;
        send_byte(8'h11, 0);
        for (int i = 0; i < 7; i++) send_bit(1'b1, 0);
        @(negedge clk); bit_valid = 1'b1; bit_in = 1'b0;
        @(negedge clk); bit_valid = 1'b0; rd_stb = 1'b1; d = rd_data;
        @(negedge clk); rd_stb = 1'b0;
        chk("R10 old byte read", d, 8'h11);
        chk("R10 new byte held", rd_data, 8'h7F);
        chk("R10 full set", full_flag, 1);
        chk("R10 no overrun", overrun_flag, 0);
        host_read(d);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_lsb_first;
        t_latency;
        t_gaps;
        t_match;
        t_full_irq;
        t_simul;
        done_flag = 1'b1;
    end

    initial begin
        fork
            wait (done_flag);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog actual=1 expected=0");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule